// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Controller

This block sits behind a serial receiver and files the bytes it delivers into memory. Memory is a small dual-port RAM of 32-bit words. The host reaches it through one port, and the controller uses the other. The host builds a ring of two-word descriptors in that RAM. Word 0 holds control and status in bits 31:16 and a length in bits 15:0. Word 1 holds the word address of a data buffer in its low bits.

The controller walks the ring. It only uses a descriptor whose empty bit hands it to the controller. It packs received bytes into that descriptor's buffer. When the buffer is full or the frame ends, it closes the descriptor with flags and a length, and it may raise an event. It then moves on to the next descriptor, or back to the ring base when the descriptor carries the wrap bit.

Frame ends arrive either as a plain end strobe or as one of three error strobes: overrun, carrier lost, or missing bit-cell transition. The host side is a word-wide RAM port plus three registers: ring base (address 0), event (address 1, write-one-to-clear) and event mask (address 2). The event register uses bit 0 for "descriptor closed" and bit 1 for "busy".

Top module: `rx_bd_ring`

## Requirements
- R1: After reset the event register, the mask register, the ring base register and `irq` are all zero, and the controller starts at descriptor word 0.
- R2: Data is stored only into a descriptor whose empty bit (word 0 bit 31) is 1. Outside continuous mode, closing the descriptor writes this bit as 0.
- R3: After closing a descriptor with the wrap bit (bit 30) set, the controller fetches the descriptor at the ring base. Otherwise it fetches the descriptor two words further on, so the ring length is fixed only by where the wrap bit sits.
- R4: Byte n of a buffer goes to word `ptr + n/4`, byte lane n mod 4, with lane 0 in bits 7:0. Other lanes keep their contents. After BUF_BYTES bytes the descriptor closes with the last flag 0 and length BUF_BYTES.
- R5: The first-in-frame flag (bit 26) is 1 only in the descriptor that stored the byte marked with `rx_sof`.
- R6: A frame end closes the current descriptor with the last-in-frame flag (bit 27) set and the length equal to the total number of bytes in the frame.
- R7: Closing a descriptor whose interrupt bit (bit 29) is 1 sets event bit 0 on the second clock edge after the edge that samples the frame end. `irq` is high exactly while some event bit and its mask bit are both 1.
- R8: Writing a 1 to an event bit clears it; writing a 0 leaves it unchanged.
- R9: With the continuous bit (bit 28) set, a close leaves the empty bit at 1 so the same buffer is refilled on the next visit. An error end still writes the empty bit as 0.
- R10: `err_ovr`, `err_cd` and `err_dpll` each end the frame and set bit 16, bit 17 and bit 18 of the closing descriptor respectively.
- R11: `rx_end` together with `rx_nonoctet` sets the non-octet flag (bit 19) in the closing descriptor.
- R12: When the controller meets a descriptor with the empty bit clear, it raises event bit 1 once, discards incoming bytes and frame ends, and re-reads that descriptor until it becomes owned.
- R13: A close writes descriptor bits 25:20 as zero and keeps the wrap, interrupt and continuous bits as the host wrote them.
- R14: A write to the ring base register makes the controller restart at the new base the next time it fetches a descriptor, or at once when it is waiting idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One received byte on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | With `rx_valid`: this byte starts a frame |
| rx_end | input | 1 | Frame end without error (carrier dropped) |
| rx_nonoctet | input | 1 | With `rx_end`: bit count not a multiple of eight |
| err_ovr | input | 1 | Overrun error; ends the frame |
| err_cd | input | 1 | Carrier lost error; ends the frame |
| err_dpll | input | 1 | Missing bit-cell transition; ends the frame |
| ram_we | input | 1 | Host RAM write |
| ram_addr | input | ADDR_W | Host RAM word address |
| ram_wdata | input | 32 | Host RAM write data |
| ram_rdata | output | 32 | Host RAM read data, one cycle after the address |
| reg_we | input | 1 | Host register write |
| reg_addr | input | 2 | Register select: 0 base, 1 event, 2 mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Masked event request |

## Verification
A byte strobe is captured on the first edge and lands in RAM on the second edge. A frame end is captured on the first edge, moves the controller to its closing state on the second, and writes the descriptor and event bit on the third edge after it is driven. The bench holds every strobe for one cycle and then idles eight cycles before the next one. That gap covers a full-buffer close plus the next descriptor fetch, so descriptors and buffers can be read back safely after each frame. The interrupt timing is pinned down separately: `irq` is sampled at the falling edges just before and just after the edge where the event must appear. Host reads of RAM are taken one full cycle after the address is driven.

// File: rtl/rbd_pkg.sv
// Package: shared encodings for the receive descriptor ring controller.
// Status bit positions are relative to the upper half of descriptor word 0.
package rbd_pkg;
    localparam int ST_EMPTY = 15;
    localparam int ST_WRAP  = 14;
    localparam int ST_INT   = 13;
    localparam int ST_CONT  = 12;
    localparam int ST_LAST  = 11;
    localparam int ST_FIRST = 10;
    localparam int ST_NOCT  = 3;
    localparam int ST_CLKE  = 2;
    localparam int ST_CDL   = 1;
    localparam int ST_OVR   = 0;

    localparam int EV_RX   = 0;
    localparam int EV_BUSY = 1;

    // end-of-frame cause vector: {non-octet, clock error, carrier lost, overrun}
    typedef logic [3:0] end_flags_t;

    typedef enum logic [2:0] {
        S_RD0   = 3'd0,
        S_RD1   = 3'd1,
        S_CAP   = 3'd2,
        S_READY = 3'd3,
        S_CLOSE = 3'd4,
        S_NOWN  = 3'd5
    } eng_state_t;
endpackage

// File: rtl/rbd_dpram.sv
// Module: dual-port word RAM holding descriptors and buffers.
// Port A (host) writes whole words; port B (controller) writes byte lanes.
// Both ports read synchronously with one cycle latency. Assumes the two
// ports never write the same word in the same cycle; port B wins if so.
module rbd_dpram #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [31:0]       a_wdata,
    output logic [31:0]       a_rdata,
    input  logic [3:0]        b_be,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [31:0]       b_wdata,
    output logic [31:0]       b_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [31:0] mem [DEPTH];

    // writes from both ports, byte lanes on port B
    always_ff @(posedge clk) begin
        if (a_we) begin
            mem[a_addr] <= a_wdata;
        end
        for (int l = 0; l < 4; l++) begin
            if (b_be[l]) begin
                mem[b_addr][l*8 +: 8] <= b_wdata[l*8 +: 8];
            end
        end
    end

    // registered reads for both ports
    always_ff @(posedge clk) begin
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/rbd_rx_capture.sv
// Module: one-deep holding slots between the receiver and the engine.
// A byte slot and a frame-end slot are kept apart so that an end strobe
// may follow the last byte closely. Assumes bytes are spaced far enough
// apart that the engine takes each one before the next arrives.
module rbd_rx_capture (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [7:0]          rx_data,
    input  logic                rx_sof,
    input  logic                rx_end,
    input  logic                rx_nonoctet,
    input  logic                err_ovr,
    input  logic                err_cd,
    input  logic                err_dpll,
    input  logic                take_byte,
    input  logic                take_end,
    output logic                byte_pend,
    output logic [7:0]          byte_data,
    output logic                byte_sof,
    output logic                end_pend,
    output rbd_pkg::end_flags_t end_flags
);
    import rbd_pkg::*;

    logic       end_src;
    end_flags_t new_flags;

    // frame-end sources and their cause bits
    always_comb begin
        end_src   = rx_end | err_ovr | err_cd | err_dpll;
        new_flags = {rx_end & rx_nonoctet, err_dpll, err_cd, err_ovr};
    end

    // byte slot: a new byte overrides, a take empties
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_pend <= 1'b0;
            byte_data <= '0;
            byte_sof  <= 1'b0;
        end else if (rx_valid) begin
            byte_pend <= 1'b1;
            byte_data <= rx_data;
            byte_sof  <= rx_sof;
        end else if (take_byte) begin
            byte_pend <= 1'b0;
        end
    end

    // end slot: causes accumulate until the engine takes them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_pend  <= 1'b0;
            end_flags <= '0;
        end else if (end_src) begin
            end_pend  <= 1'b1;
            end_flags <= (take_end ? '0 : end_flags) | new_flags;
        end else if (take_end) begin
            end_pend  <= 1'b0;
            end_flags <= '0;
        end
    end
endmodule

// File: rtl/rbd_regs.sv
// Module: host registers - ring base, event (write-one-to-clear) and mask.
// Event sets from the engine win over a clear in the same cycle. Raises
// base_wr for one cycle on each ring base write.
module rbd_regs #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [1:0]        ev_set,
    output logic [ADDR_W-1:0] base,
    output logic              base_wr,
    output logic [1:0]        ev_q,
    output logic              irq
);
    logic [1:0] mask_q;
    logic       unused_wd;

    assign unused_wd = ^reg_wdata[31:ADDR_W];

    // register writes and event accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base    <= '0;
            base_wr <= 1'b0;
            mask_q  <= '0;
            ev_q    <= '0;
        end else begin
            base_wr <= reg_we && (reg_addr == 2'd0);
            if (reg_we && reg_addr == 2'd0) begin
                base <= reg_wdata[ADDR_W-1:0];
            end
            if (reg_we && reg_addr == 2'd2) begin
                mask_q <= reg_wdata[1:0];
            end
            if (reg_we && reg_addr == 2'd1) begin
                ev_q <= (ev_q & ~reg_wdata[1:0]) | ev_set;
            end else begin
                ev_q <= ev_q | ev_set;
            end
        end
    end

    // read mux
    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = {{(32-ADDR_W){1'b0}}, base};
            2'd1:    reg_rdata = {30'd0, ev_q};
            2'd2:    reg_rdata = {30'd0, mask_q};
            default: reg_rdata = '0;
        endcase
    end

    // masked request
    assign irq = |(ev_q & mask_q);
endmodule

// File: rtl/rbd_engine.sv
// Module: descriptor walker. It fetches word 0 and word 1 of the current
// descriptor, stores bytes into the buffer while it owns the descriptor,
// closes it with status and length, and advances or wraps. A descriptor
// that is not owned is re-read until it is, with incoming data dropped.
// Assumes BUF_BYTES >= 4 and buffers that do not cross the RAM end.
module rbd_engine #(
    parameter int ADDR_W    = 8,
    parameter int BUF_BYTES = 8,
    localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    base,
    input  logic                 base_wr,
    input  logic                 byte_pend,
    input  logic [7:0]           byte_data,
    input  logic                 byte_sof,
    input  logic                 end_pend,
    input  rbd_pkg::end_flags_t  end_flags,
    output logic                 take_byte,
    output logic                 take_end,
    output logic [3:0]           m_be,
    output logic [ADDR_W-1:0]    m_addr,
    output logic [31:0]          m_wdata,
    input  logic [31:0]          m_rdata,
    output logic [1:0]           ev_set,
    output rbd_pkg::eng_state_t  state,
    output logic [ADDR_W-1:0]    cur,
    output logic                 restart_req,
    output logic [15:0]          close_st,
    output logic [CNT_W-1:0]     cnt
);
    import rbd_pkg::*;

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_BYTES);

    logic [15:0]       w0;
    logic [ADDR_W-1:0] ptr;
    logic [15:0]       frame_cnt;
    logic              desc_first;
    logic              busy_flag;
    logic              last_r;
    end_flags_t        flags_r;
    logic [15:0]       close_len;
    logic              close_err;
    logic [CNT_W-1:0]  cnt_inc;
    logic              ready_restart;
    logic              restart_done;
    logic              unused_rd;

    assign unused_rd = ^m_rdata[15:ADDR_W];
    assign cnt_inc   = cnt + CNT_W'(1);

    // idle restart: owned descriptor, nothing stored, nothing waiting
    assign ready_restart = (state == S_READY) && restart_req && (cnt == '0)
                           && !byte_pend && !end_pend;

    // status word and length written on close
    always_comb begin
        close_err           = last_r && (|flags_r[2:0]);
        close_st            = '0;
        close_st[ST_EMPTY]  = w0[ST_CONT] && !close_err;
        close_st[ST_WRAP]   = w0[ST_WRAP];
        close_st[ST_INT]    = w0[ST_INT];
        close_st[ST_CONT]   = w0[ST_CONT];
        close_st[ST_LAST]   = last_r;
        close_st[ST_FIRST]  = desc_first;
        close_st[ST_NOCT]   = last_r && flags_r[3];
        close_st[ST_CLKE]   = last_r && flags_r[2];
        close_st[ST_CDL]    = last_r && flags_r[1];
        close_st[ST_OVR]    = last_r && flags_r[0];
        close_len           = last_r ? frame_cnt : 16'(cnt);
    end

    // RAM port B address, lanes and data per state
    always_comb begin
        m_addr  = cur;
        m_be    = '0;
        m_wdata = '0;
        case (state)
            S_RD1:   m_addr = cur + ADDR_W'(1);
            S_READY: begin
                if (byte_pend) begin
                    m_addr  = ptr + ADDR_W'(cnt >> 2);
                    m_be    = 4'b0001 << cnt[1:0];
                    m_wdata = {4{byte_data}};
                end
            end
            S_CLOSE: begin
                m_be    = 4'hF;
                m_wdata = {close_st, close_len};
            end
            default: ;
        endcase
    end

    // slot takes and event pulses
    always_comb begin
        take_byte       = ((state == S_READY) || (state == S_NOWN)) && byte_pend;
        take_end        = (((state == S_READY) && !byte_pend) || (state == S_NOWN))
                          && end_pend;
        ev_set          = '0;
        ev_set[EV_RX]   = (state == S_CLOSE) && w0[ST_INT];
        ev_set[EV_BUSY] = (state == S_NOWN) && !busy_flag;
    end

    // a restart is consumed wherever the pointer reloads from base
    assign restart_done = restart_req &&
                          ((state == S_CAP) || (state == S_NOWN) ||
                           (state == S_CLOSE) || ready_restart);

    // pending restart request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_req <= 1'b0;
        end else begin
            restart_req <= base_wr || (restart_req && !restart_done);
        end
    end

    // descriptor walk and buffer fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_RD0;
            cur        <= '0;
            w0         <= '0;
            ptr        <= '0;
            cnt        <= '0;
            frame_cnt  <= '0;
            desc_first <= 1'b0;
            busy_flag  <= 1'b0;
            last_r     <= 1'b0;
            flags_r    <= '0;
        end else begin
            case (state)
                S_RD0: state <= S_RD1;
                S_RD1: begin
                    w0    <= m_rdata[31:16];
                    state <= S_CAP;
                end
                S_CAP: begin
                    ptr <= m_rdata[ADDR_W-1:0];
                    if (restart_req) begin
                        cur       <= base;
                        busy_flag <= 1'b0;
                        state     <= S_RD0;
                    end else if (w0[ST_EMPTY]) begin
                        busy_flag <= 1'b0;
                        state     <= S_READY;
                    end else begin
                        state <= S_NOWN;
                    end
                end
                S_NOWN: begin
                    busy_flag <= 1'b1;
                    if (end_pend) begin
                        frame_cnt <= '0;
                    end
                    if (restart_req) begin
                        cur       <= base;
                        busy_flag <= 1'b0;
                    end
                    state <= S_RD0;
                end
                S_READY: begin
                    if (ready_restart) begin
                        cur   <= base;
                        state <= S_RD0;
                    end else if (byte_pend) begin
                        cnt       <= cnt_inc;
                        frame_cnt <= byte_sof ? 16'd1 : frame_cnt + 16'd1;
                        if (byte_sof) begin
                            desc_first <= 1'b1;
                        end
                        if (cnt_inc == CNT_FULL) begin
                            last_r  <= 1'b0;
                            flags_r <= '0;
                            state   <= S_CLOSE;
                        end
                    end else if (end_pend) begin
                        last_r  <= 1'b1;
                        flags_r <= end_flags;
                        state   <= S_CLOSE;
                    end
                end
                S_CLOSE: begin
                    cnt        <= '0;
                    desc_first <= 1'b0;
                    if (last_r) begin
                        frame_cnt <= '0;
                    end
                    if (restart_req || w0[ST_WRAP]) begin
                        cur <= base;
                    end else begin
                        cur <= cur + ADDR_W'(2);
                    end
                    state <= S_RD0;
                end
                default: state <= S_RD0;
            endcase
        end
    end
endmodule

// File: rtl/rx_bd_ring.sv
// Module: top of the receive descriptor ring controller. Connects the
// receive holding slots, the descriptor engine, the host registers and the
// shared dual-port RAM. Assumes the host leaves owned descriptors alone.
module rx_bd_ring #(
    parameter int ADDR_W    = 8,
    parameter int BUF_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_end,
    input  logic              rx_nonoctet,
    input  logic              err_ovr,
    input  logic              err_cd,
    input  logic              err_dpll,
    input  logic              ram_we,
    input  logic [ADDR_W-1:0] ram_addr,
    input  logic [31:0]       ram_wdata,
    output logic [31:0]       ram_rdata,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    import rbd_pkg::*;

    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    logic                byte_pend, byte_sof, end_pend;
    logic [7:0]          byte_data;
    end_flags_t          end_flags;
    logic                take_byte, take_end;
    logic [3:0]          m_be;
    logic [ADDR_W-1:0]   m_addr;
    logic [31:0]         m_wdata, m_rdata;
    logic [1:0]          ev_set, ev_q;
    logic [ADDR_W-1:0]   ring_base, eng_cur;
    logic                base_wr, eng_restart;
    eng_state_t          eng_state;
    logic [15:0]         eng_close_st;
    logic [CNT_W-1:0]    eng_cnt;

    rbd_rx_capture u_cap (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
        .rx_end(rx_end), .rx_nonoctet(rx_nonoctet),
        .err_ovr(err_ovr), .err_cd(err_cd), .err_dpll(err_dpll),
        .take_byte(take_byte), .take_end(take_end),
        .byte_pend(byte_pend), .byte_data(byte_data), .byte_sof(byte_sof),
        .end_pend(end_pend), .end_flags(end_flags)
    );

    rbd_engine #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .base(ring_base), .base_wr(base_wr),
        .byte_pend(byte_pend), .byte_data(byte_data), .byte_sof(byte_sof),
        .end_pend(end_pend), .end_flags(end_flags),
        .take_byte(take_byte), .take_end(take_end),
        .m_be(m_be), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .ev_set(ev_set), .state(eng_state), .cur(eng_cur),
        .restart_req(eng_restart), .close_st(eng_close_st), .cnt(eng_cnt)
    );

    rbd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ev_set(ev_set), .base(ring_base),
        .base_wr(base_wr), .ev_q(ev_q), .irq(irq)
    );

    rbd_dpram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk),
        .a_we(ram_we), .a_addr(ram_addr), .a_wdata(ram_wdata), .a_rdata(ram_rdata),
        .b_be(m_be), .b_addr(m_addr), .b_wdata(m_wdata), .b_rdata(m_rdata)
    );
endmodule

// File: rtl/rx_bd_ring_chk.sv
// Module: property checker bound to rx_bd_ring. Watches the engine state,
// ring pointer, event register and controller RAM lanes.
module rx_bd_ring_chk #(
    parameter int ADDR_W    = 8,
    parameter int BUF_BYTES = 8,
    localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input rbd_pkg::eng_state_t state,
    input logic [ADDR_W-1:0]   cur,
    input logic [ADDR_W-1:0]   base,
    input logic                restart_req,
    input logic [15:0]         close_st,
    input logic [1:0]          ev,
    input logic [1:0]          ev_set,
    input logic [3:0]          m_be,
    input logic [CNT_W-1:0]    cnt
);
    import rbd_pkg::*;

    // R7: a close of an interrupting descriptor shows in the event register
    p_rx_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLOSE && close_st[ST_INT]) |=> ev[EV_RX]);

    // R3: a wrapping close returns to the ring base
    p_wrap_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLOSE && close_st[ST_WRAP]) |=> (cur == $past(base)));

    // R3: a plain close steps two words
    p_step_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLOSE && !close_st[ST_WRAP] && !restart_req)
        |=> (cur == $past(cur) + ADDR_W'(2)));

    // R12: nothing is written while the descriptor is not owned
    p_no_store_unowned_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_NOWN) |-> (m_be == 4'b0000));

    // R12: the busy event is a single pulse per stall
    p_busy_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set[EV_BUSY] |=> !ev_set[EV_BUSY]);

    // R4: the byte count never passes the buffer size
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BUF_BYTES));

    // R4: at most one byte lane is written outside a close
    p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_CLOSE) |-> $onehot0(m_be));
endmodule

bind rx_bd_ring rx_bd_ring_chk #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(eng_state), .cur(eng_cur), .base(ring_base),
    .restart_req(eng_restart), .close_st(eng_close_st), .ev(ev_q),
    .ev_set(ev_set), .m_be(m_be), .cnt(eng_cnt)
);

// File: tb/tb_rx_bd_ring.sv
module tb_rx_bd_ring;
    localparam int ADDR_W = 8;

    localparam logic [31:0] D_E  = 32'h8000_0000;
    localparam logic [31:0] D_W  = 32'h4000_0000;
    localparam logic [31:0] D_I  = 32'h2000_0000;
    localparam logic [31:0] D_CM = 32'h1000_0000;
    localparam logic [31:0] D_L  = 32'h0800_0000;
    localparam logic [31:0] D_F  = 32'h0400_0000;
    localparam logic [31:0] D_NO = 32'h0008_0000;
    localparam logic [31:0] D_DE = 32'h0004_0000;
    localparam logic [31:0] D_CD = 32'h0002_0000;
    localparam logic [31:0] D_OV = 32'h0001_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_end = 1'b0, rx_nonoctet = 1'b0;
    logic [7:0] rx_data = '0;
    logic err_ovr = 1'b0, err_cd = 1'b0, err_dpll = 1'b0;
    logic ram_we = 1'b0;
    logic [ADDR_W-1:0] ram_addr = '0;
    logic [31:0] ram_wdata = '0, ram_rdata;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_bd_ring #(.ADDR_W(ADDR_W), .BUF_BYTES(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
        .rx_end(rx_end), .rx_nonoctet(rx_nonoctet),
        .err_ovr(err_ovr), .err_cd(err_cd), .err_dpll(err_dpll),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ram_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        ram_we = 1'b1; ram_addr = a; ram_wdata = d;
        @(negedge clk);
        ram_we = 1'b0;
    endtask

    task automatic ram_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        ram_addr = a;
        @(negedge clk);
        d = ram_rdata;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic sof);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_sof = sof;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
        idle(8);
    endtask

    task automatic send_end(input logic no, input logic ov, input logic cd, input logic de);
        @(negedge clk);
        rx_end = ~(ov | cd | de); rx_nonoctet = no;
        err_ovr = ov; err_cd = cd; err_dpll = de;
        @(negedge clk);
        rx_end = 1'b0; rx_nonoctet = 1'b0; err_ovr = 1'b0; err_cd = 1'b0; err_dpll = 1'b0;
        idle(8);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_rd(2'd1, d); chk("R1 event after reset", d, 32'h0);
        reg_rd(2'd0, d); chk("R1 base after reset", d, 32'h0);
        reg_rd(2'd2, d); chk("R1 mask after reset", d, 32'h0);
        chk("R1 irq after reset", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        ram_wr(8'h80, 32'h0);
        ram_wr(8'h01, 32'h80);
        ram_wr(8'h00, D_E | D_W | D_I | 32'h03F0_1234);
        reg_wr(2'd2, 32'h1);
        reg_wr(2'd0, 32'h0);
        idle(10);
        reg_wr(2'd1, 32'h3);
        send_byte(8'hA1, 1'b1);
        send_byte(8'hB2, 1'b0);
        send_byte(8'hC3, 1'b0);
        // precise event timing: end sampled at t0, event due at t2
        @(negedge clk);
        rx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
        chk("R7 irq low after sampling edge", {31'd0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq low after first edge", {31'd0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq high after second edge", {31'd0, irq}, 32'h1);
        idle(8);
        ram_rd(8'h00, d); chk("R6 R13 R2 closed descriptor", d, D_W | D_I | D_L | D_F | 32'd3);
        ram_rd(8'h80, d); chk("R4 packed bytes", d, 32'h00C3_B2A1);
        reg_rd(2'd1, d); chk("R7 event bit 0", d & 32'h1, 32'h1);
        reg_wr(2'd1, 32'h0);
        reg_rd(2'd1, d); chk("R8 zero write keeps event", d & 32'h1, 32'h1);
        reg_wr(2'd1, 32'h1);
        reg_rd(2'd1, d); chk("R8 event cleared", d & 32'h1, 32'h0);
        chk("R7 irq drops with event", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        ram_wr(8'h88, 32'h0); ram_wr(8'h89, 32'h0); ram_wr(8'h90, 32'h0);
        ram_wr(8'h11, 32'h88); ram_wr(8'h10, D_E);
        ram_wr(8'h13, 32'h90); ram_wr(8'h12, D_E | D_W);
        reg_wr(2'd0, 32'h10);
        reg_rd(2'd0, d); chk("R14 base readback", d, 32'h10);
        idle(10);
        for (int i = 0; i < 10; i++) send_byte(8'(8'h10 + i), i == 0);
        send_end(1'b0, 1'b0, 1'b0, 1'b0);
        ram_rd(8'h10, d); chk("R4 R5 R14 full buffer close", d, D_F | 32'd8);
        ram_rd(8'h88, d); chk("R4 buffer word 0", d, 32'h1312_1110);
        ram_rd(8'h89, d); chk("R4 buffer word 1", d, 32'h1716_1514);
        ram_rd(8'h12, d); chk("R6 R5 R3 frame tail", d, D_W | D_L | 32'd10);
        ram_rd(8'h90, d); chk("R4 R3 tail bytes", d, 32'h0000_1918);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        ram_wr(8'h98, 32'h0); ram_wr(8'h9C, 32'h0);
        ram_wr(8'h21, 32'h98); ram_wr(8'h20, D_E);
        ram_wr(8'h23, 32'h9C); ram_wr(8'h22, D_E | D_W);
        reg_wr(2'd0, 32'h20);
        idle(10);
        send_byte(8'h31, 1'b1); send_end(1'b0, 1'b0, 1'b0, 1'b0);
        send_byte(8'h32, 1'b1); send_end(1'b0, 1'b0, 1'b0, 1'b0);
        ram_wr(8'h20, D_E);
        idle(10);
        send_byte(8'h33, 1'b1); send_end(1'b0, 1'b0, 1'b0, 1'b0);
        ram_rd(8'h22, d); chk("R3 wrap descriptor", d, D_W | D_L | D_F | 32'd1);
        ram_rd(8'h9C, d); chk("R3 second buffer", d, 32'h0000_0032);
        ram_rd(8'h98, d); chk("R3 wrapped to base", d, 32'h0000_0033);
        ram_rd(8'h20, d); chk("R3 R2 base descriptor reused", d, D_L | D_F | 32'd1);
    endtask

    task automatic t_cont();
        logic [31:0] d;
        ram_wr(8'hA0, 32'h0);
        ram_wr(8'h31, 32'hA0); ram_wr(8'h30, D_E | D_W | D_CM);
        reg_wr(2'd0, 32'h30);
        idle(10);
        send_byte(8'h11, 1'b1); send_byte(8'h22, 1'b0); send_end(1'b0, 1'b0, 1'b0, 1'b0);
        ram_rd(8'h30, d); chk("R9 continuous keeps empty", d, D_E | D_W | D_CM | D_L | D_F | 32'd2);
        send_byte(8'h33, 1'b1); send_end(1'b0, 1'b0, 1'b0, 1'b0);
        ram_rd(8'hA0, d); chk("R9 buffer overwritten", d, 32'h0000_2233);
        ram_rd(8'h30, d); chk("R9 second close", d, D_E | D_W | D_CM | D_L | D_F | 32'd1);
        send_byte(8'h44, 1'b1); send_end(1'b0, 1'b1, 1'b0, 1'b0);
        ram_rd(8'h30, d); chk("R9 error releases", d, D_W | D_CM | D_L | D_F | D_OV | 32'd1);
    endtask

    task automatic t_errors();
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
            ram_wr(8'(8'hA4 + 2 * k), 32'h0);
            ram_wr(8'(8'h41 + 2 * k), 32'(8'hA4 + 2 * k));
            ram_wr(8'(8'h40 + 2 * k), (k == 3) ? (D_E | D_W) : D_E);
        end
        reg_wr(2'd0, 32'h40);
        idle(10);
        send_byte(8'h01, 1'b1); send_end(1'b0, 1'b0, 1'b1, 1'b0);
        send_byte(8'h02, 1'b1); send_end(1'b0, 1'b0, 1'b0, 1'b1);
        send_byte(8'h03, 1'b1); send_end(1'b1, 1'b0, 1'b0, 1'b0);
        send_byte(8'h04, 1'b1); send_end(1'b0, 1'b1, 1'b0, 1'b0);
        ram_rd(8'h40, d); chk("R10 carrier lost", d, D_L | D_F | D_CD | 32'd1);
        ram_rd(8'h42, d); chk("R10 clock error", d, D_L | D_F | D_DE | 32'd1);
        ram_rd(8'h44, d); chk("R11 non-octet", d, D_L | D_F | D_NO | 32'd1);
        ram_rd(8'h46, d); chk("R10 overrun", d, D_W | D_L | D_F | D_OV | 32'd1);
        ram_rd(8'hA6, d); chk("R10 data kept on error", d, 32'h0000_0002);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        ram_wr(8'hB0, 32'h0);
        ram_wr(8'h51, 32'hB0); ram_wr(8'h50, D_W);
        reg_wr(2'd1, 32'h3);
        reg_wr(2'd0, 32'h50);
        idle(10);
        reg_rd(2'd1, d); chk("R12 busy event", d & 32'h2, 32'h2);
        chk("R12 busy masked off irq", {31'd0, irq}, 32'h0);
        send_byte(8'h5A, 1'b1); send_end(1'b0, 1'b0, 1'b0, 1'b0);
        ram_rd(8'hB0, d); chk("R12 byte discarded", d, 32'h0);
        ram_rd(8'h50, d); chk("R12 descriptor untouched", d, D_W);
        ram_wr(8'h50, D_E | D_W);
        idle(10);
        send_byte(8'h6B, 1'b1); send_end(1'b0, 1'b0, 1'b0, 1'b0);
        ram_rd(8'hB0, d); chk("R12 resumes when owned", d, 32'h0000_006B);
        ram_rd(8'h50, d); chk("R12 R6 length after resume", d, D_W | D_L | D_F | 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_basic();
        t_multi();
        t_wrap();
        t_cont();
        t_errors();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule